// File: doc/BRIEF.md
# I2C Register Access Master

This block is a bus master for a two-wire serial bus that carries out complete register transactions against a slave device with internally addressed storage. A host loads a command through a small set of inputs and pulses a go strobe. The command holds a 7-bit device address, an internal register address of one or two bytes, a transfer direction, a byte count and up to `MAX_BYTES` bytes of write data. The block then runs the whole transaction in hardware with no further help from the host. A write sends the device address, the register address and the data bytes, then closes with a stop. A read is a random read. It first writes the register address, then issues a repeated start, re-addresses the device for reading, takes one byte, answers it with a not-acknowledge and closes with a stop.

Both bus lines are open-drain. The block only ever pulls a line low through an output enable, and it reads the actual SDA level back on a separate input. A parameter `DIV` sets the length of each quarter of a bit period, so one SCL period is `4*DIV` system clocks. When the slave fails to acknowledge any byte the master sent, the block raises an error flag, stops the bus and returns to idle.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `done` and `ack_err` are 0 and `rd_data` is 8'h00.
- R2: Every bus slot (start, repeated start, one data or acknowledge bit, stop) lasts exactly `4*DIV` clocks. If a transaction uses S slots, `done` is first seen high `4*DIV*S+1` rising edges after `cmd_go` is applied, counting the edge that accepts the strobe as the first.
- R3: The first byte after the start is `{cmd_dev, 1'b0}`, sent MSB first, so the device address goes out bit 6 first and the write bit (0) comes last.
- R4: With `cmd_addr2`=1 the register address is sent as `cmd_reg[15:8]` and then `cmd_reg[7:0]`. With `cmd_addr2`=0 only `cmd_reg[7:0]` is sent. Each byte goes out MSB first and is followed by an acknowledge slot.
- R5: With `cmd_read`=0, data bytes follow the register address. Byte i comes from `cmd_wdata[8*i+7:8*i]` and is sent MSB first with its own acknowledge slot. The byte count is `cmd_len`, a value of 0 sends one byte, and a value above `MAX_BYTES` sends `MAX_BYTES` bytes. A stop follows the last byte.
- R6: With `cmd_read`=1, the register address is followed by a repeated start and then `{cmd_dev, 1'b1}`. One byte is then received MSB first and appears on `rd_data` when `done` is high. A write, or a read that ended in error, leaves `rd_data` unchanged.
- R7: In the ninth bit slot of the received byte the master leaves SDA released, which is a not-acknowledge, and then issues a stop.
- R8: If SDA reads high in the acknowledge slot of any byte the master sent, `ack_err` goes to 1, no further byte is sent, a stop follows and `done` pulses. `ack_err` holds until the next accepted `cmd_go` clears it.
- R9: SDA changes while SCL is high only to form a start (falling) or a stop (rising). A write has exactly one start and one stop. A complete read has two starts and one stop.
- R10: `busy` is high from the edge that accepts `cmd_go` until the edge that raises `done`. `done` is a single-cycle pulse. A `cmd_go` that arrives while `busy` is high is ignored.
- R11: While `busy` is low, both `scl_oe` and `sda_oe` are 0, so both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start strobe, accepted only when idle |
| cmd_read | input | 1 | 1 = random read, 0 = write |
| cmd_addr2 | input | 1 | 1 = two register address bytes, 0 = one |
| cmd_dev | input | 7 | Slave device address |
| cmd_reg | input | 16 | Register address, high byte used only with `cmd_addr2` |
| cmd_len | input | $clog2(MAX_BYTES+1) | Number of write data bytes |
| cmd_wdata | input | 8*MAX_BYTES | Write data, byte i in bits 8i+7..8i |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| ack_err | output | 1 | Slave failed to acknowledge |
| rd_data | output | 8 | Byte received by the last successful read |

## Verification
The only result whose timing is fixed is `done`, which is due `4*DIV*S+1` rising edges after the strobe, where S is the slot count the bench derives from the command and from where the error is injected. The bench counts edges from the strobe, samples at each falling edge, and compares the count at which `done` first appears against that figure. `rd_data`, `ack_err` and `busy` are compared on that same falling edge, and `done` is checked again one edge later to confirm it is a single pulse. The bus content (bytes, start and stop counts, and the master's not-acknowledge level) is gathered by a slave model that reacts to SCL edges, and it is compared once the transaction is over.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
  typedef enum logic [1:0] {WAVE_IDLE, WAVE_START, WAVE_BIT, WAVE_STOP} wave_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_SEND, ST_RECV, ST_STOP} state_e;
  typedef enum logic [2:0] {SEG_DEV_W, SEG_REG_HI, SEG_REG_LO, SEG_DATA, SEG_DEV_R} seg_e;
endpackage

// File: rtl/i2c_rm_phase.sv
// Quarter-bit timebase: tick closes each quarter of DIV clocks.
module i2c_rm_phase #(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic       tick,
  output logic [1:0] quarter
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (tick) begin
      cnt     <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rm_wave.sv
// Maps slot shape and quarter onto registered open-drain enables.
module i2c_rm_wave
  import i2c_rm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wave_e      shape,
  input  logic [1:0] quarter,
  input  logic       level,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic scl_n, sda_n, scl_up;

  assign scl_up = (quarter == 2'd1) || (quarter == 2'd2);

  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    case (shape)
      WAVE_START: begin
        scl_n = !scl_up;
        sda_n = quarter[1];        // SDA falls in the second high quarter
      end
      WAVE_BIT: begin
        scl_n = !scl_up;
        sda_n = !level;
      end
      WAVE_STOP: begin
        scl_n = (quarter == 2'd0);
        sda_n = !quarter[1];       // SDA rises while SCL stays high
      end
      default: begin
        scl_n = 1'b0;
        sda_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_n;
      sda_oe <= sda_n;
    end
  end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_rm_pkg::*;
#(
  parameter int DIV       = 8,
  parameter int MAX_BYTES = 4,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int IW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int WW = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic          cmd_read,
  input  logic          cmd_addr2,
  input  logic [6:0]    cmd_dev,
  input  logic [15:0]   cmd_reg,
  input  logic [LW-1:0] cmd_len,
  input  logic [WW-1:0] cmd_wdata,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          ack_err,
  output logic [7:0]    rd_data
);
  state_e         st;
  seg_e           seg;
  logic [3:0]     bitn;
  logic [7:0]     shreg;
  logic [IW-1:0]  idx, idx_nxt, last_q, len_last;
  logic [6:0]     dev_q;
  logic [15:0]    reg_q;
  logic           addr2_q, rd_q, ack_hi;
  logic [WW-1:0]  wbuf;
  logic           tick, mid, slot_end;
  logic [1:0]     quarter;
  wave_e          shape;
  logic           level;

  i2c_rm_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .run(busy), .tick(tick), .quarter(quarter)
  );

  assign mid      = tick && (quarter == 2'd2);
  assign slot_end = tick && (quarter == 2'd3);
  assign busy     = (st != ST_IDLE);
  assign idx_nxt  = idx + 1'b1;

  // Clamp the requested byte count to 1..MAX_BYTES, expressed as last index.
  always_comb begin
    if (cmd_len == '0)
      len_last = '0;
    else if (cmd_len > LW'(MAX_BYTES))
      len_last = IW'(MAX_BYTES - 1);
    else
      len_last = IW'(cmd_len - 1'b1);
  end

  always_comb begin
    case (st)
      ST_START: shape = WAVE_START;
      ST_SEND,
      ST_RECV:  shape = WAVE_BIT;
      ST_STOP:  shape = WAVE_STOP;
      default:  shape = WAVE_IDLE;
    endcase
    level = (st == ST_SEND && bitn != 4'd8) ? shreg[7] : 1'b1;
  end

  i2c_rm_wave u_wave (
    .clk(clk), .rst(rst), .shape(shape), .quarter(quarter), .level(level),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      seg     <= SEG_DEV_W;
      bitn    <= 4'd0;
      shreg   <= 8'h00;
      idx     <= '0;
      last_q  <= '0;
      dev_q   <= 7'h00;
      reg_q   <= 16'h0000;
      addr2_q <= 1'b0;
      rd_q    <= 1'b0;
      ack_hi  <= 1'b0;
      wbuf    <= '0;
      done    <= 1'b0;
      ack_err <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_go) begin
            dev_q   <= cmd_dev;
            reg_q   <= cmd_reg;
            addr2_q <= cmd_addr2;
            rd_q    <= cmd_read;
            wbuf    <= cmd_wdata;
            last_q  <= len_last;
            ack_err <= 1'b0;
            seg     <= SEG_DEV_W;
            st      <= ST_START;
          end
        end
        ST_START: begin
          if (slot_end) begin
            st    <= ST_SEND;
            bitn  <= 4'd0;
            shreg <= {dev_q, (seg == SEG_DEV_R)};
          end
        end
        ST_SEND: begin
          if (mid && bitn == 4'd8) ack_hi <= sda_in;
          if (slot_end) begin
            if (bitn != 4'd8) begin
              bitn  <= bitn + 4'd1;
              shreg <= {shreg[6:0], 1'b0};
            end else if (ack_hi) begin
              ack_err <= 1'b1;
              st      <= ST_STOP;
            end else begin
              bitn <= 4'd0;
              case (seg)
                SEG_DEV_W: begin
                  seg   <= addr2_q ? SEG_REG_HI : SEG_REG_LO;
                  shreg <= addr2_q ? reg_q[15:8] : reg_q[7:0];
                end
                SEG_REG_HI: begin
                  seg   <= SEG_REG_LO;
                  shreg <= reg_q[7:0];
                end
                SEG_REG_LO: begin
                  if (rd_q) begin
                    seg <= SEG_DEV_R;
                    st  <= ST_START;     // repeated start
                  end else begin
                    seg   <= SEG_DATA;
                    idx   <= '0;
                    shreg <= wbuf[7:0];
                  end
                end
                SEG_DATA: begin
                  if (idx == last_q) begin
                    st <= ST_STOP;
                  end else begin
                    idx   <= idx_nxt;
                    shreg <= wbuf[idx_nxt*8 +: 8];
                  end
                end
                SEG_DEV_R: st <= ST_RECV;
                default:   st <= ST_STOP;
              endcase
            end
          end
        end
        ST_RECV: begin
          if (mid && bitn != 4'd8) shreg <= {shreg[6:0], sda_in};
          if (slot_end) begin
            if (bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
            end else begin
              rd_data <= shreg;          // ninth slot was the master NACK
              st      <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (slot_end) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rm_checks.sv
module i2c_rm_checks (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       ack_err,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] rd_data
);
  p_idle_released_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  p_scl_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(scl_oe));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_err_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ack_err);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> $stable(rd_data));
endmodule

bind i2c_reg_master i2c_rm_checks u_checks (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ack_err(ack_err),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_data(rd_data)
);

// File: tb/tb_i2c_reg_master.sv
module tb_i2c_reg_master;
  localparam int DIV  = 4;
  localparam int MAXB = 4;
  localparam int LW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cmd_go = 0, cmd_read = 0, cmd_addr2 = 0;
  logic [6:0]    cmd_dev = '0;
  logic [15:0]   cmd_reg = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [31:0]   cmd_wdata = '0;
  logic          scl_oe, sda_oe, busy, done, ack_err;
  logic [7:0]    rd_data;
  logic          s_oe = 1'b0;
  logic          scl_bus, sda_bus;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || s_oe);

  i2c_reg_master #(.DIV(DIV), .MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_read(cmd_read),
    .cmd_addr2(cmd_addr2), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .ack_err(ack_err), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  localparam int S_IDLE = 0, S_RX = 1, S_ACK = 2, S_TX = 3, S_MACK = 4;
  int         sst = S_IDLE, scnt = 0, nstart = 0, nstop = 0, nlog = 0, nak_at = -1;
  logic [7:0] slog [0:15];
  logic [7:0] ssh = '0, stx = '0, rd_byte = '0;
  logic       scl_q = 1, sda_q = 1, sfirst = 0, sread = 0, sacked = 0, mack = 0;

  always @(negedge clk) begin
    if (rst) begin
      sst = S_IDLE; s_oe = 0;
    end else if (scl_bus && scl_q && sda_q && !sda_bus) begin
      nstart++; sst = S_RX; scnt = 0; sfirst = 1; s_oe = 0;
    end else if (scl_bus && scl_q && !sda_q && sda_bus) begin
      nstop++; sst = S_IDLE; s_oe = 0;
    end else if (scl_bus && !scl_q) begin
      if (sst == S_RX) begin ssh = {ssh[6:0], sda_bus}; scnt++; end
      else if (sst == S_TX) scnt++;
      else if (sst == S_MACK) begin mack = sda_bus; sst = S_IDLE; end
    end else if (!scl_bus && scl_q) begin
      if (sst == S_RX && scnt == 8) begin
        if (nlog < 16) slog[nlog] = ssh;
        sacked = (nlog != nak_at);
        s_oe   = sacked;
        sread  = sfirst && ssh[0];
        sfirst = 0;
        nlog++;
        sst = S_ACK;
      end else if (sst == S_ACK) begin
        s_oe = 0;
        if (sacked && sread) begin
          stx = rd_byte; s_oe = !stx[7]; scnt = 0; sst = S_TX;
        end else if (sacked) begin
          sst = S_RX; scnt = 0;
        end else sst = S_IDLE;
      end else if (sst == S_TX) begin
        if (scnt < 8) s_oe = !stx[7 - scnt];
        else begin s_oe = 0; sst = S_MACK; end
      end
    end
    scl_q = scl_bus;
    sda_q = sda_bus;
  end

  // ---------------- transaction driver ----------------
  logic [7:0] prev_rd = 8'h00;

  task automatic run_txn(input bit rd, input bit two, input logic [6:0] dev,
                         input logic [15:0] ra, input logic [LW-1:0] len,
                         input logic [31:0] wd, input int nak, input bit poke);
    logic [7:0] ex [0:15];
    int nex, a, eff, slots, cyc;
    bit err, rs;
    string tag;
    nex = 0;
    a   = two ? 2 : 1;
    eff = (len == 0) ? 1 : ((int'(len) > MAXB) ? MAXB : int'(len));
    ex[nex] = {dev, 1'b0}; nex++;
    if (two) begin ex[nex] = ra[15:8]; nex++; end
    ex[nex] = ra[7:0]; nex++;
    if (rd) begin ex[nex] = {dev, 1'b1}; nex++; end
    else for (int i = 0; i < eff; i++) begin ex[nex] = wd[i*8 +: 8]; nex++; end
    err = (nak >= 0) && (nak < nex);
    if (err) nex = nak + 1;
    rs    = rd && (nex == a + 2);
    slots = 2 + 9 * nex + (rs ? 1 : 0) + ((rd && !err) ? 9 : 0);

    rd_byte = 8'($urandom);
    nak_at = nak; nstart = 0; nstop = 0; nlog = 0; mack = 0;

    @(negedge clk);
    cmd_read = rd; cmd_addr2 = two; cmd_dev = dev; cmd_reg = ra;
    cmd_len = len; cmd_wdata = wd; cmd_go = 1;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 1) cmd_go = 0;
      if (cyc == 2) begin
        chk("R8 ack_err cleared by new start", int'(ack_err), 0);
        chk("R10 busy during transfer", int'(busy), 1);
      end
      if (poke && cyc == 40) begin cmd_go = 1; cmd_read = !rd; cmd_dev = ~dev; end
      if (poke && cyc == 41) cmd_go = 0;
      if (done) break;
      if (cyc > 20000) begin
        chk("R2 watchdog expired", cyc, 0);
        break;
      end
    end

    chk("R2 duration to done", cyc, 4 * DIV * slots + 1);
    chk("R3 bytes seen by slave", nlog, nex);
    for (int i = 0; i < nex && i < nlog && i < 16; i++) begin
      if (i == 0) tag = "R3 device write byte";
      else if (i <= a) tag = "R4 register address byte";
      else if (rd) tag = "R6 device read byte";
      else tag = "R5 data byte";
      chk(tag, int'(slog[i]), int'(ex[i]));
    end
    chk("R8 ack_err", int'(ack_err), int'(err));
    chk("R9 start count", nstart, rs ? 2 : 1);
    chk("R9 stop count", nstop, 1);
    if (rd && !err) begin
      chk("R6 read data", int'(rd_data), int'(rd_byte));
      chk("R7 master not-acknowledge", int'(mack), 1);
      prev_rd = rd_byte;
    end else begin
      chk("R6 read data held", int'(rd_data), int'(prev_rd));
    end
    chk("R10 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
    chk("R11 lines released", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    void'($urandom(32'd7919));
    repeat (8) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset scl_oe", int'(scl_oe), 0);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ack_err", int'(ack_err), 0);
    chk("R1 reset rd_data", int'(rd_data), 0);

    // directed corners
    run_txn(0, 0, 7'h50, 16'h0012, 3'd1, 32'h000000A7, -1, 0);
    run_txn(0, 1, 7'h2A, 16'hBEEF, 3'd4, 32'h81C3E5F7, -1, 0);
    run_txn(0, 1, 7'h11, 16'h1234, 3'd0, 32'h000000FF, -1, 0);   // R5 len 0
    run_txn(0, 0, 7'h7F, 16'h00F0, 3'd7, 32'h55AA33CC, -1, 0);   // R5 clamp
    run_txn(1, 0, 7'h48, 16'h003C, 3'd1, 32'h0, -1, 0);
    run_txn(1, 1, 7'h1D, 16'hA55A, 3'd1, 32'h0, -1, 0);
    run_txn(0, 0, 7'h22, 16'h0001, 3'd2, 32'h00001234, 0, 0);   // R8 device NAK
    run_txn(1, 1, 7'h33, 16'h0F0F, 3'd1, 32'h0, 1, 0);          // R8 reg NAK
    run_txn(1, 0, 7'h44, 16'h0080, 3'd1, 32'h0, 2, 0);          // R8 NAK on read addr
    run_txn(0, 1, 7'h05, 16'h7777, 3'd4, 32'hDEADBEEF, 4, 0);   // R8 NAK mid-data
    run_txn(1, 1, 7'h66, 16'h4321, 3'd1, 32'h0, -1, 1);         // R10 go while busy
    run_txn(0, 0, 7'h0C, 16'h0099, 3'd3, 32'h00C0FFEE, -1, 1);

    // constrained random
    for (int t = 0; t < 25; t++) begin
      int nk;
      nk = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : -1;
      run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 7'($urandom),
              16'($urandom), LW'($urandom_range(0, 7)), $urandom, nk, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule